// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block supervises a 64-bit timer that has been configured for watchdog duty. Software arms it with an ordered pair of 16-bit key writes to a single 32-bit control word. Each key write must carry the enable bit. The first key is accepted only when the attached timer reports that it is ready. Once armed, the controller watches two things: the timer's expiry indication, and every further write to the control word.

While the watchdog is armed, software services it by writing the first key and then the second key. That pair produces a one-cycle pulse asking the timer to clear its 64-bit count. Any of the following raises a system reset request: a write whose key is neither of the two keys, or an expiry of the count against its period. The request stays high until the block's own reset is applied. The timer, clock control and reset distribution sit outside this block.

Top module: `keyed_wdog_ctrl`

## Requirements
- R1: After reset, `wd_state` reads 0 (idle), `wd_en` is 0, and `rst_req` and `cnt_clear` are low. The `wd_state` encoding is 0 idle, 1 pre-armed, 2 armed, 3 armed with a service pending.
- R2: The control word carries the enable bit at bit 14 and the key at bits [31:16]. While not armed, every write copies bit 14 into `wd_en` on the next edge.
- R3: From idle, a write with key 0xA5C6 and bit 14 set moves to pre-armed. This happens only when all of the following hold: `timer_mode` equals 2, `lo_half_live` and `hi_half_live` are high, and `count_zero` is high. Otherwise the state stays idle.
- R4: From pre-armed, a write with key 0xDA7E and bit 14 set moves to armed. The same write in idle leaves the state idle.
- R5: In pre-armed, another 0xA5C6 write with bit 14 set keeps the state pre-armed. Any other write returns the state to idle.
- R6: While armed (state 2 or 3), a write whose key is neither 0xA5C6 nor 0xDA7E raises `rst_req` on the next edge. The value 0x00004000 is one such write.
- R7: While armed, a high `cnt_timeout` raises `rst_req` on the next edge. In idle or pre-armed, `cnt_timeout` has no effect on `rst_req`.
- R8: While armed, a 0xA5C6 write moves to state 3. A following 0xDA7E write gives a single-cycle `cnt_clear` pulse and returns to state 2. A 0xDA7E write in state 2 gives no pulse and no reset request.
- R9: Once high, `rst_req` stays high until `rst_n` is low at a clock edge. While armed, `wd_en` stays 1 whatever bit 14 of a write holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| timer_mode | input | 2 | Mode field of the attached timer (2 = watchdog) |
| lo_half_live | input | 1 | Lower timer half out of reset |
| hi_half_live | input | 1 | Upper timer half out of reset |
| count_zero | input | 1 | Timer counters and periods are cleared |
| cnt_timeout | input | 1 | Timer count has reached its period |
| wd_state | output | 2 | Controller state |
| wd_en | output | 1 | Watchdog enable bit |
| cnt_clear | output | 1 | One-cycle request to clear the timer count |
| rst_req | output | 1 | Sticky system reset request |

## Verification
A wrong key-state value shows on `wd_state` at the first negative edge after the write that caused it. It also shows as a missing or spurious `rst_req` or `cnt_clear` one cycle after the next write. An enable bit that drops while armed is visible on `wd_en` immediately after the offending write. A reset request that was not held shows after the following idle cycle. Each scenario therefore samples the state one cycle after every write, and samples it again after idle cycles.

// File: rtl/wdk_pkg.sv
// Shared types for the keyed watchdog controller.
// Assumes a two-bit state encoding that is also visible on the top ports.
package wdk_pkg;
    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_PRE     = 2'd1,
        WD_RUN     = 2'd2,
        WD_RUN_SVC = 2'd3
    } wd_state_e;

    // Classification of one control-word write
    typedef struct packed {
        logic arm;      // key field equals the first key
        logic fire;     // key field equals the second key
        logic en;       // enable bit of the written value
        logic setup_ok; // attached timer is ready for watchdog duty
    } wr_class_t;
endpackage

// File: rtl/wdk_decode.sv
// Field extraction and key classification for control-word writes.
// Purely combinational. Assumes the key field and enable bit positions fit
// inside DATA_W.
module wdk_decode
    import wdk_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                KEY_LSB   = 16,
    parameter int                KEY_W     = 16,
    parameter int                EN_POS    = 14,
    parameter logic [KEY_W-1:0]  KEY_ARM   = 16'hA5C6,
    parameter logic [KEY_W-1:0]  KEY_FIRE  = 16'hDA7E,
    parameter int                MODE_W    = 2,
    parameter logic [MODE_W-1:0] MODE_WDOG = 2'd2
) (
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] timer_mode,
    input  logic              lo_half_live,
    input  logic              hi_half_live,
    input  logic              count_zero,
    output wr_class_t         cls
);
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    logic [KEY_W-1:0] key_field;

    // Slice the key and classify the write against both keys and timer readiness
    always_comb begin
        key_field    = wr_data[KEY_MSB:KEY_LSB];
        cls.arm      = (key_field == KEY_ARM);
        cls.fire     = (key_field == KEY_FIRE);
        cls.en       = wr_data[EN_POS];
        cls.setup_ok = (timer_mode == MODE_WDOG) && lo_half_live
                       && hi_half_live && count_zero;
    end
endmodule

// File: rtl/wdk_fsm.sv
// Key-sequence state machine and enable bit.
// Flags a trip (bad key or expiry while armed) and a completed service pair.
// Assumes wr_en is a single-cycle strobe per write; reset is synchronous,
// active low.
module wdk_fsm
    import wdk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  wr_class_t cls,
    input  logic      cnt_timeout,
    output wd_state_e state_q,
    output logic      en_q,
    output logic      trip,
    output logic      svc
);
    wd_state_e state_d;
    logic      active;

    // Armed covers both the plain and the service-pending states
    always_comb active = (state_q == WD_RUN) || (state_q == WD_RUN_SVC);

    // Next-state selection for the key sequence
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                WD_IDLE:
                    if (cls.arm && cls.en && cls.setup_ok) state_d = WD_PRE;
                WD_PRE:
                    if (cls.arm && cls.en)       state_d = WD_PRE;
                    else if (cls.fire && cls.en) state_d = WD_RUN;
                    else                         state_d = WD_IDLE;
                WD_RUN:
                    if (cls.arm) state_d = WD_RUN_SVC;
                WD_RUN_SVC:
                    if (cls.fire) state_d = WD_RUN;
                default: state_d = WD_IDLE;
            endcase
        end
    end

    // Trip on a bad key or an expiry while armed; service on the second key of a pair
    always_comb begin
        trip = active && ((wr_en && !cls.arm && !cls.fire) || cnt_timeout);
        svc  = (state_q == WD_RUN_SVC) && wr_en && cls.fire;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    // Enable bit: follows writes until armed, then held set
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (active)  en_q <= 1'b1;
        else if (wr_en)   en_q <= cls.en;
    end

    // R3: arming is refused while the timer is not ready
    assert_no_arm_unready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE && wr_en && !cls.setup_ok) |=> (state_q == WD_IDLE));

    // R4: the armed state is never entered straight from idle
    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE) |=> (state_q == WD_IDLE || state_q == WD_PRE));

    // R9: enable cannot drop while armed
    assert_en_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> en_q);
endmodule

// File: rtl/wdk_trip.sv
// Reset-request and counter-clear generation.
// Latches any trip into a sticky reset request and registers the service
// pulse. Assumes a synchronous active-low reset.
module wdk_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic svc,
    output logic rst_req,
    output logic cnt_clear
);
    // Sticky reset request, released only by the block reset
    always_ff @(posedge clk) begin
        if (!rst_n)    rst_req <= 1'b0;
        else if (trip) rst_req <= 1'b1;
    end

    // Single-cycle counter clear on a completed service pair
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_clear <= 1'b0;
        else        cnt_clear <= svc;
    end

    // R9: the request holds until reset
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R6: a trip always raises the request on the next edge
    assert_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> rst_req);
endmodule

// File: rtl/keyed_wdog_ctrl.sv
// Keyed watchdog reset controller: top level.
// Decodes control writes, runs the two-key arming sequence, and drives the
// sticky reset request and the counter clear for an external 64-bit timer.
// Assumes the timer compares count against period itself and reports expiry
// on cnt_timeout.
module keyed_wdog_ctrl
    import wdk_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                KEY_LSB   = 16,
    parameter int                KEY_W     = 16,
    parameter int                EN_POS    = 14,
    parameter logic [KEY_W-1:0]  KEY_ARM   = 16'hA5C6,
    parameter logic [KEY_W-1:0]  KEY_FIRE  = 16'hDA7E,
    parameter int                MODE_W    = 2,
    parameter logic [MODE_W-1:0] MODE_WDOG = 2'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] timer_mode,
    input  logic              lo_half_live,
    input  logic              hi_half_live,
    input  logic              count_zero,
    input  logic              cnt_timeout,
    output logic [1:0]        wd_state,
    output logic              wd_en,
    output logic              cnt_clear,
    output logic              rst_req
);
    wr_class_t cls;
    wd_state_e state_q;
    logic      trip;
    logic      svc;

    wdk_decode #(
        .DATA_W(DATA_W), .KEY_LSB(KEY_LSB), .KEY_W(KEY_W), .EN_POS(EN_POS),
        .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE),
        .MODE_W(MODE_W), .MODE_WDOG(MODE_WDOG)
    ) u_decode (
        .wr_data      (wr_data),
        .timer_mode   (timer_mode),
        .lo_half_live (lo_half_live),
        .hi_half_live (hi_half_live),
        .count_zero   (count_zero),
        .cls          (cls)
    );

    wdk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .cls         (cls),
        .cnt_timeout (cnt_timeout),
        .state_q     (state_q),
        .en_q        (wd_en),
        .trip        (trip),
        .svc         (svc)
    );

    wdk_trip u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip      (trip),
        .svc       (svc),
        .rst_req   (rst_req),
        .cnt_clear (cnt_clear)
    );

    // Expose the state encoding on the port
    always_comb wd_state = state_q;

    // R8: a clear pulse only follows a pending service
    assert_clear_after_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |-> ($past(wd_state) == 2'd3));

    // R7: a new request only comes from the armed states
    assert_req_from_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(wd_state) >= 2'd2));
endmodule

// File: tb/test_keyed_wdog_ctrl.sv
module test_keyed_wdog_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EN    = 32'h0000_4000;
    localparam logic [31:0] K_ARM = 32'hA5C6_0000;
    localparam logic [31:0] K_FIR = 32'hDA7E_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  timer_mode = 2'd2;
    logic        lo_half_live = 1'b1;
    logic        hi_half_live = 1'b1;
    logic        count_zero = 1'b1;
    logic        cnt_timeout = 1'b0;
    logic [1:0]  wd_state;
    logic        wd_en;
    logic        cnt_clear;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdog_ctrl i_keyed_wdog_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .timer_mode(timer_mode), .lo_half_live(lo_half_live),
        .hi_half_live(hi_half_live), .count_zero(count_zero),
        .cnt_timeout(cnt_timeout), .wd_state(wd_state), .wd_en(wd_en),
        .cnt_clear(cnt_clear), .rst_req(rst_req)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        cnt_timeout = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write; returns at the negedge after the capturing posedge
    task automatic write(logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_timeout();
        cnt_timeout = 1'b1;
        @(negedge clk);
        cnt_timeout = 1'b0;
    endtask

    task automatic arm_fully();
        write(K_ARM | EN);
        write(K_FIR | EN);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", wd_state, 0);
        check("R1 en", wd_en, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 cnt_clear", cnt_clear, 0);
    endtask

    task automatic t_setup_and_enable();
        do_reset();
        timer_mode = 2'd1;
        write(K_ARM | EN);
        check("R3 mode not watchdog", wd_state, 0);
        check("R2 en copied", wd_en, 1);
        timer_mode = 2'd2;
        count_zero = 1'b0;
        write(K_ARM | EN);
        check("R3 not cleared", wd_state, 0);
        count_zero = 1'b1;
        hi_half_live = 1'b0;
        write(K_ARM | EN);
        check("R3 half in reset", wd_state, 0);
        hi_half_live = 1'b1;
        write(32'h0);
        check("R2 en cleared", wd_en, 0);
        write(K_ARM);
        check("R3 no enable bit", wd_state, 0);
    endtask

    task automatic t_pre_armed();
        do_reset();
        write(K_FIR | EN);
        check("R4 second key in idle", wd_state, 0);
        write(K_ARM | EN);
        check("R3 pre-armed", wd_state, 1);
        write(K_ARM | EN);
        check("R5 repeat first key", wd_state, 1);
        pulse_timeout();
        check("R7 timeout ignored pre-armed", rst_req, 0);
        write(32'h1234_4000);
        check("R5 wrong key drops", wd_state, 0);
        check("R5 no reset", rst_req, 0);
        write(K_ARM | EN);
        write(K_FIR | EN);
        check("R4 armed", wd_state, 2);
    endtask

    task automatic t_service();
        do_reset();
        arm_fully();
        write(K_FIR | EN);
        check("R8 lone second key state", wd_state, 2);
        check("R8 lone second key no clear", cnt_clear, 0);
        check("R8 lone second key no reset", rst_req, 0);
        write(K_ARM);
        check("R8 pending", wd_state, 3);
        check("R9 en held", wd_en, 1);
        write(K_FIR);
        check("R8 clear pulse", cnt_clear, 1);
        check("R8 back to armed", wd_state, 2);
        @(negedge clk);
        check("R8 pulse one cycle", cnt_clear, 0);
        check("R8 no reset", rst_req, 0);
    endtask

    task automatic t_bad_key();
        do_reset();
        arm_fully();
        write(32'h0000_4000);
        check("R6 bad key reset", rst_req, 1);
        repeat (5) @(negedge clk);
        check("R9 sticky", rst_req, 1);
        do_reset();
        check("R9 cleared by reset", rst_req, 0);
        arm_fully();
        write(K_ARM | EN);
        write(32'hFFFF_4000);
        check("R6 bad key while pending", rst_req, 1);
    endtask

    task automatic t_timeout();
        do_reset();
        pulse_timeout();
        check("R7 timeout ignored idle", rst_req, 0);
        arm_fully();
        check("R7 quiet before expiry", rst_req, 0);
        pulse_timeout();
        check("R7 expiry reset", rst_req, 1);
    endtask

    initial begin
        t_reset();
        t_setup_and_enable();
        t_pre_armed();
        t_service();
        t_bad_key();
        t_timeout();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule